// File: doc/BRIEF.md
# Sparse Hit Readout Formatter

This block walks every pixel address of a sensor region and asks an external flag store whether that pixel was hit. Pixels without a hit are passed over. For each hit pixel the block builds a fixed-length record from three parts: the column address, the row address and the time stamp read back with the flag. Each part carries two parity bits. The block then sends the record out one bit per clock, with a strobe that marks the record's bits.

A single start pulse launches a full scan. Queries go out through an address port with a query strobe, and the flag store returns the hit flag and time stamp one cycle later. While a record is being shifted, no new query is issued. When the last address has been visited and the final record has left, a one-cycle done pulse is given. Several copies can serve separate regions of one sensor in parallel.

Top module: `sparse_hit_fmt`

## Requirements
- R1: While reset is high and in the cycle after it is released, qry_en, ser_frame, ser_data and scan_done are all 0.
- R2: A start pulse seen while idle begins a scan at column 0, row 0. Columns advance fastest, and after the last column the row steps by one. Each address is presented exactly once, with qry_en high for one cycle. The flag and time inputs are sampled in the cycle after that query.
- R3: Only pixels whose returned flag is 1 produce a record, so a region with no flags set produces no frame at all.
- R4: A record is 44 bits for default widths. It is sent most significant bit first in the order column field, row field, time field. Each field is its payload (column 12 bits, row 14 bits, time 12 bits), then the even-parity bit over the payload's upper half, then the even-parity bit over its lower half. Each parity bit is the XOR of its half. Halves split at payload width / 2, so bits 11:6 and 5:0 for 12 bits, and 13:7 and 6:0 for 14 bits.
- R5: Record bits appear on ser_data one per clock. ser_frame is high for exactly 44 consecutive cycles per record and low between records.
- R6: No query is issued while ser_frame is high. After a record, the scan continues with the next address in R2 order.
- R7: scan_done is high for exactly one cycle per scan. It comes after the last address has been checked and any record from it has been fully sent. If the final pixel was hit, scan_done is high in the cycle right after that record's last bit. If the final pixel was empty, no frame is high when it asserts.
- R8: A start pulse that arrives while a scan is running has no effect on the addresses queried, the records sent or the number of done pulses.
- R9: After scan_done, a new start pulse performs a complete new scan with the same results for the same flag contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a scan of the region |
| flag_in | input | 1 | Hit flag of the queried pixel, valid the cycle after qry_en |
| time_in | input | T_W | Time stamp of the queried pixel, valid with flag_in |
| qry_en | output | 1 | Query strobe for the address on qry_col/qry_row |
| qry_col | output | X_W | Column address being queried |
| qry_row | output | Y_W | Row address being queried |
| ser_data | output | 1 | Serial record bit, MSB first |
| ser_frame | output | 1 | High during each of a record's bit-times |
| scan_done | output | 1 | One-cycle pulse at the end of a scan |

## Verification
Two events can land on the same clock: the last bit of the final pixel's record and the end of the address range. A hit is placed on the very last pixel to force this. The bench then checks that scan_done rises in the first cycle after the frame drops, that the frame still lasted the full record length, and that the record matches the one computed in the bench. A second overlap comes from a start pulse that arrives mid-scan. The bench judges it by comparing the full query address trace and record list against a run without the extra pulse.

// File: rtl/sparse_hit_pkg.sv
package sparse_hit_pkg;

  typedef enum logic [2:0] {
    SC_IDLE,
    SC_ASK,
    SC_LOOK,
    SC_SEND,
    SC_FIN
  } scan_state_e;

  // Width of a protected field: payload plus two parity bits.
  function automatic int fld_len(input int payload_w);
    return payload_w + 2;
  endfunction

endpackage

// File: rtl/field_parity_enc.sv
module field_parity_enc #(
  parameter int W = 12
) (
  input  logic [W-1:0] val,
  output logic [W+1:0] fld
);
  localparam int LO_W = W / 2;

  logic par_hi, par_lo;

  // Even parity: each bit makes its half plus itself hold an even count of ones.
  assign par_hi = ^val[W-1:LO_W];
  assign par_lo = ^val[LO_W-1:0];
  assign fld    = {val, par_hi, par_lo};
endmodule

// File: rtl/record_shifter.sv
module record_shifter #(
  parameter int REC_W = 44
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [REC_W-1:0] rec,
  output logic             sdo,
  output logic             frame,
  output logic             last
);
  localparam int CW = $clog2(REC_W);
  localparam logic [CW-1:0] CNT_TOP = CW'(REC_W - 1);

  logic [REC_W-1:0] sreg;
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg  <= '0;
      cnt   <= '0;
      frame <= 1'b0;
    end else if (load) begin
      sreg  <= rec;
      cnt   <= CNT_TOP;
      frame <= 1'b1;
    end else if (frame) begin
      if (cnt == '0) begin
        frame <= 1'b0;
        sreg  <= '0;
      end else begin
        sreg <= {sreg[REC_W-2:0], 1'b0};
        cnt  <= cnt - 1'b1;
      end
    end
  end

  assign sdo  = sreg[REC_W-1];
  assign last = frame && (cnt == '0);
endmodule

// File: rtl/hit_scan_ctrl.sv
module hit_scan_ctrl
  import sparse_hit_pkg::*;
#(
  parameter int N_COL = 2200,
  parameter int N_ROW = 12500,
  parameter int X_W   = 12,
  parameter int Y_W   = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           flag_in,
  input  logic           shift_last,
  output logic           qry_en,
  output logic [X_W-1:0] qry_col,
  output logic [Y_W-1:0] qry_row,
  output logic           load_rec,
  output logic           scan_done
);
  localparam logic [X_W-1:0] COL_LAST = X_W'(N_COL - 1);
  localparam logic [Y_W-1:0] ROW_LAST = Y_W'(N_ROW - 1);

  scan_state_e    state;
  logic [X_W-1:0] col, col_nx;
  logic [Y_W-1:0] row, row_nx;
  logic           at_end;

  assign at_end = (col == COL_LAST) && (row == ROW_LAST);

  always_comb begin
    if (col == COL_LAST) begin
      col_nx = '0;
      row_nx = row + 1'b1;
    end else begin
      col_nx = col + 1'b1;
      row_nx = row;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SC_IDLE;
      col   <= '0;
      row   <= '0;
    end else begin
      case (state)
        SC_IDLE: if (start) begin
          col   <= '0;
          row   <= '0;
          state <= SC_ASK;
        end
        SC_ASK:  state <= SC_LOOK;
        SC_LOOK: begin
          if (flag_in) begin
            state <= SC_SEND;
          end else if (at_end) begin
            state <= SC_FIN;
          end else begin
            col   <= col_nx;
            row   <= row_nx;
            state <= SC_ASK;
          end
        end
        SC_SEND: if (shift_last) begin
          if (at_end) begin
            state <= SC_FIN;
          end else begin
            col   <= col_nx;
            row   <= row_nx;
            state <= SC_ASK;
          end
        end
        SC_FIN:  state <= SC_IDLE;
        default: state <= SC_IDLE;
      endcase
    end
  end

  assign qry_en    = (state == SC_ASK);
  assign qry_col   = col;
  assign qry_row   = row;
  assign load_rec  = (state == SC_LOOK) && flag_in;
  assign scan_done = (state == SC_FIN);
endmodule

// File: rtl/sparse_hit_fmt.sv
module sparse_hit_fmt
  import sparse_hit_pkg::*;
#(
  parameter int N_COL = 2200,
  parameter int N_ROW = 12500,
  parameter int X_W   = 12,
  parameter int Y_W   = 14,
  parameter int T_W   = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           flag_in,
  input  logic [T_W-1:0] time_in,
  output logic           qry_en,
  output logic [X_W-1:0] qry_col,
  output logic [Y_W-1:0] qry_row,
  output logic           ser_data,
  output logic           ser_frame,
  output logic           scan_done
);
  localparam int XF_W  = fld_len(X_W);
  localparam int YF_W  = fld_len(Y_W);
  localparam int TF_W  = fld_len(T_W);
  localparam int REC_W = XF_W + YF_W + TF_W;

  logic              load_rec, shift_last;
  logic [XF_W-1:0]   x_fld;
  logic [YF_W-1:0]   y_fld;
  logic [TF_W-1:0]   t_fld;

  hit_scan_ctrl #(
    .N_COL(N_COL), .N_ROW(N_ROW), .X_W(X_W), .Y_W(Y_W)
  ) scan_i (
    .clk(clk), .rst(rst), .start(start), .flag_in(flag_in),
    .shift_last(shift_last), .qry_en(qry_en), .qry_col(qry_col),
    .qry_row(qry_row), .load_rec(load_rec), .scan_done(scan_done)
  );

  field_parity_enc #(.W(X_W)) xenc_i (.val(qry_col), .fld(x_fld));
  field_parity_enc #(.W(Y_W)) yenc_i (.val(qry_row), .fld(y_fld));
  field_parity_enc #(.W(T_W)) tenc_i (.val(time_in), .fld(t_fld));

  record_shifter #(.REC_W(REC_W)) shift_i (
    .clk(clk), .rst(rst), .load(load_rec), .rec({x_fld, y_fld, t_fld}),
    .sdo(ser_data), .frame(ser_frame), .last(shift_last)
  );
endmodule

// File: rtl/sparse_hit_fmt_chk.sv
module sparse_hit_fmt_chk #(
  parameter int N_COL = 2200,
  parameter int N_ROW = 12500,
  parameter int X_W   = 12,
  parameter int Y_W   = 14,
  parameter int REC_W = 44
) (
  input logic           clk,
  input logic           rst,
  input logic           qry_en,
  input logic [X_W-1:0] qry_col,
  input logic [Y_W-1:0] qry_row,
  input logic           ser_frame,
  input logic           scan_done
);
  localparam int RW = $clog2(REC_W) + 2;

  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)            run_len <= '0;
    else if (ser_frame) run_len <= run_len + 1'b1;
    else                run_len <= '0;
  end

  p_frame_short_r5: assert property (@(posedge clk) disable iff (rst)
    ser_frame |-> (run_len < RW'(REC_W)));

  p_frame_full_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_frame) |-> (run_len == RW'(REC_W)));

  p_no_query_in_frame_r6: assert property (@(posedge clk) disable iff (rst)
    ser_frame |-> !qry_en);

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    scan_done |=> !scan_done);

  p_done_after_frame_r7: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> !ser_frame);

  p_addr_range_r2: assert property (@(posedge clk) disable iff (rst)
    qry_en |-> ((qry_col < X_W'(N_COL)) && (qry_row < Y_W'(N_ROW))));

  p_query_single_r2: assert property (@(posedge clk) disable iff (rst)
    qry_en |=> !qry_en);
endmodule

bind sparse_hit_fmt sparse_hit_fmt_chk #(
  .N_COL(N_COL), .N_ROW(N_ROW), .X_W(X_W), .Y_W(Y_W), .REC_W(REC_W)
) chk_i (
  .clk(clk), .rst(rst), .qry_en(qry_en), .qry_col(qry_col),
  .qry_row(qry_row), .ser_frame(ser_frame), .scan_done(scan_done)
);

// File: tb/sparse_hit_fmt_tb_top.sv
module sparse_hit_fmt_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_COL = 70;
  localparam int N_ROW = 3;
  localparam int X_W = 12, Y_W = 14, T_W = 12;
  localparam int REC_W = 44;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic flag_in = 1'b0;
  logic [T_W-1:0] time_in = '0;
  logic qry_en, ser_data, ser_frame, scan_done;
  logic [X_W-1:0] qry_col;
  logic [Y_W-1:0] qry_row;

  always #(CLK_PERIOD/2) clk = ~clk;

  sparse_hit_fmt #(.N_COL(N_COL), .N_ROW(N_ROW), .X_W(X_W), .Y_W(Y_W), .T_W(T_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .flag_in(flag_in), .time_in(time_in),
    .qry_en(qry_en), .qry_col(qry_col), .qry_row(qry_row),
    .ser_data(ser_data), .ser_frame(ser_frame), .scan_done(scan_done));

  // Flag store model: one-cycle read latency.
  logic           hit_m [N_ROW][N_COL];
  logic [T_W-1:0] tm_m  [N_ROW][N_COL];
  always @(posedge clk) begin
    if (qry_en) begin
      flag_in <= hit_m[qry_row][qry_col];
      time_in <= tm_m[qry_row][qry_col];
    end else begin
      flag_in <= 1'b0;
    end
  end

  int checks = 0, failures = 0, done_cnt = 0;
  bit finished = 0;
  logic [REC_W-1:0] got_q[$];
  int addr_q[$];
  logic [REC_W-1:0] cur;
  int bitcnt = 0, run = 0;
  logic prev_fv = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Serial monitor.
  always @(negedge clk) begin
    if (rst) begin
      bitcnt = 0; run = 0; prev_fv = 0;
    end else begin
      if (qry_en) addr_q.push_back(int'(qry_row) * N_COL + int'(qry_col));
      if (ser_frame) begin
        cur = {cur[REC_W-2:0], ser_data};
        bitcnt++; run++;
        if (qry_en) chk(0, "R6 query during frame", 1, 0);
      end else if (prev_fv) begin
        chk(run == REC_W, "R5 frame length", run, REC_W);
        if (bitcnt == REC_W) got_q.push_back(cur);
        bitcnt = 0; run = 0;
      end
      if (scan_done) done_cnt++;
      prev_fv = ser_frame;
    end
  end

  function automatic logic [REC_W-1:0] exp_rec(input int c, input int r, input logic [11:0] t);
    logic [11:0] x;
    logic [13:0] y;
    x = 12'(c);
    y = 14'(r);
    return {x, ^x[11:6], ^x[5:0], y, ^y[13:7], ^y[6:0], t, ^t[11:6], ^t[5:0]};
  endfunction

  task automatic clear_map();
    for (int r = 0; r < N_ROW; r++)
      for (int c = 0; c < N_COL; c++) begin
        hit_m[r][c] = 1'b0;
        tm_m[r][c]  = 12'(r * 37 + c * 11);
      end
  endtask

  // Runs one scan and compares everything against the map.
  task automatic run_scan(input string tag, input bit extra_start, input int exp_done_after_frame);
    int n;
    int d0;
    int nexp;
    int bad;
    logic pf;
    logic [REC_W-1:0] e;
    got_q.delete();
    addr_q.delete();
    d0 = done_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0; pf = 0;
    if (extra_start) begin
      repeat (30) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (n < 30000) begin
      pf = ser_frame;
      @(negedge clk);
      n++;
      if (scan_done) break;
    end
    chk(n < 30000, {tag, " R7 done seen"}, n, 0);
    if (exp_done_after_frame >= 0)
      chk(pf == exp_done_after_frame[0], {tag, " R7 done vs final frame"}, pf, exp_done_after_frame);
    @(negedge clk);
    chk(!scan_done, {tag, " R7 done width"}, scan_done, 0);
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1, {tag, " R7/R8 done count"}, done_cnt - d0, 1);
    // R2/R6: full address order.
    bad = 0;
    if (addr_q.size() != N_ROW * N_COL) bad = 1;
    else for (int i = 0; i < N_ROW * N_COL; i++) if (addr_q[i] != i) bad++;
    chk(bad == 0, {tag, " R2 query order"}, addr_q.size(), N_ROW * N_COL);
    // R3/R4: record list.
    nexp = 0;
    for (int r = 0; r < N_ROW; r++)
      for (int c = 0; c < N_COL; c++)
        if (hit_m[r][c]) begin
          e = exp_rec(c, r, tm_m[r][c]);
          if (nexp < got_q.size())
            chk(got_q[nexp] == e, {tag, " R4 record"}, 64'(got_q[nexp]), 64'(e));
          nexp++;
        end
    chk(got_q.size() == nexp, {tag, " R3 record count"}, got_q.size(), nexp);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!qry_en && !ser_frame && !ser_data && !scan_done, "R1 in reset",
        {qry_en, ser_frame, ser_data, scan_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!qry_en && !ser_frame && !ser_data && !scan_done, "R1 after reset",
        {qry_en, ser_frame, ser_data, scan_done}, 0);
  endtask

  task automatic t_empty();
    clear_map();
    run_scan("empty R3", 0, 0);
  endtask

  task automatic t_first_pixel();
    clear_map();
    hit_m[0][0] = 1'b1; tm_m[0][0] = 12'hABC;
    run_scan("first R4", 0, 0);
  endtask

  task automatic t_last_pixel();
    clear_map();
    hit_m[N_ROW-1][N_COL-1] = 1'b1; tm_m[N_ROW-1][N_COL-1] = 12'hFFF;
    hit_m[1][65] = 1'b1; tm_m[1][65] = 12'h000;
    run_scan("last R7", 0, 1);
  endtask

  task automatic t_dense();
    clear_map();
    for (int r = 0; r < N_ROW; r++)
      for (int c = 0; c < N_COL; c++) begin
        hit_m[r][c] = 1'b1;
        tm_m[r][c] = 12'((c * 97 + r * 1013) ^ 12'h5A5);
      end
    run_scan("dense R5 R6", 0, 1);
  endtask

  task automatic t_mid_start();
    clear_map();
    hit_m[0][2] = 1'b1; hit_m[0][3] = 1'b1; hit_m[2][40] = 1'b1; tm_m[2][40] = 12'h801;
    run_scan("midstart R8", 1, 0);
  endtask

  task automatic t_rescan();
    clear_map();
    hit_m[1][0] = 1'b1; hit_m[1][N_COL-1] = 1'b1; tm_m[1][N_COL-1] = 12'h03F;
    run_scan("rescan R9 a", 0, 0);
    run_scan("rescan R9 b", 0, 0);
  endtask

  initial begin
    clear_map();
    t_reset();
    t_empty();
    t_first_pixel();
    t_last_pixel();
    t_dense();
    t_mid_start();
    t_rescan();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule